// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the fetch addresses for an in-order pipeline whose instruction set has exactly one architectural branch delay slot. It holds the address of the instruction issuing this cycle and the address being fetched behind it. From the decode information of the issuing instruction it forms a third address, which becomes the fetch address one cycle later. A branch therefore changes the fetch stream one instruction late. The instruction that sits directly behind a branch always issues, whether or not the branch is taken.

Branches may be marked as annulling. Such a branch carries a predicted direction. When the resolved direction differs from the prediction, the block raises a squash signal for the cycle in which the slot instruction issues. Downstream logic then drops that instruction, and the block ignores its decode information. For every issued instruction that is not squashed, the block records a restart context: the instruction's address, whether it sat in a delay slot, and the address that was due to follow it. A restart pulse from the trap logic replays the fetch stream from that context, so a trap taken on a slot instruction still reaches the pending branch target.

Top module: `dbs_pc_sequencer`

## Requirements
- R1: While reset is held and on release, the issue address is the reset vector (default 0x1000), the fetch address is the reset vector + 4, and the next-next address is the reset vector + 8 when no branch is presented. Squash and the in-slot flag are low.
- R2: With no branch and no restart, each clock moves the fetch address into the issue address and advances the fetch address by 4.
- R3: A taken branch issuing at address A, not squashed, is followed by the issue of A+4 (its slot) and then by the issue of its target. The target also appears on the next-next output in the branch's own cycle.
- R4: A branch that is not taken leaves the sequence unchanged: A, A+4, A+8.
- R5: An annulling branch whose taken flag differs from its predicted flag raises squash for exactly the next cycle, which is the cycle its slot issues. An annulling branch whose taken flag matches its prediction, and any non-annulling branch, leave squash low.
- R6: In a cycle with squash high, the branch inputs have no effect: the fetch stream stays sequential, squash is low in the following cycle, and the saved restart context is unchanged.
- R7: A taken branch at A with a taken branch in its slot (target T, then target U) issues A, A+4, T, U.
- R8: The in-slot flag is high in the cycle after a branch (taken or not) issues unsquashed without restart, and low after any other instruction.
- R9: Each cycle with neither squash nor restart stores the issue address, the in-slot flag and the fetch address as the saved address, saved in-slot flag and saved target.
- R10: A restart pulse ignores the branch inputs. On the next clock it loads the issue address from the saved address and the in-slot flag from the saved flag. It loads the fetch address from the saved target when the saved flag is set, and from the saved address + 4 otherwise. Squash is low after a restart.
- R11: The two low bits of every address output are zero, even for an unaligned branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_branch | input | 1 | Issuing instruction is a branch or call |
| dec_taken | input | 1 | Resolved branch direction, 1 = taken |
| dec_annul | input | 1 | Branch is of the annulling kind |
| dec_pred | input | 1 | Predicted direction of an annulling branch, 1 = taken |
| dec_target | input | 32 | Branch target address |
| trap_restart | input | 1 | Replay from the saved restart context |
| issue_pc | output | 32 | Address of the instruction issuing this cycle |
| fetch_pc | output | 32 | Address fetched this cycle, issuing next |
| next_next_pc | output | 32 | Address to be fetched next cycle |
| squash | output | 1 | Instruction issuing this cycle is cancelled |
| in_slot | output | 1 | Instruction issuing this cycle sits in a delay slot |
| saved_pc | output | 32 | Restart context: instruction address |
| saved_in_slot | output | 1 | Restart context: instruction was in a slot |
| saved_target | output | 32 | Restart context: address pending after it |

## Verification
The assertions assume that the decode inputs and the restart pulse are known, non-X values in every cycle after reset, since each clock consumes them. They also assume that a restart is only requested after reset has released, so that the saved context holds real values. The stimulus drives every input with defined values half a cycle before each clock edge. This includes cycles in which squash or restart is active, where the bench deliberately presents taken branches and unaligned targets that the block must ignore or align.

// File: rtl/dbs_pkg.sv
// Package dbs_pkg
// Shared decode bundle for the delayed-branch sequencer.
// Assumes: one issuing instruction per cycle, decoded before the clock edge.
package dbs_pkg;

    typedef struct packed {
        logic is_br;   // branch or call
        logic taken;   // resolved direction
        logic annul;   // annulling branch
        logic pred;    // predicted direction for annulling branch
    } dbs_ctl_t;

endpackage

// File: rtl/dbs_next_addr.sv
// Module dbs_next_addr
// Forms the next-next fetch address from the issuing instruction's decode
// bundle, plus the slot and squash state for the following instruction.
// Assumes: a squashed instruction's decode bundle is meaningless and is ignored.
module dbs_next_addr
    import dbs_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input  dbs_ctl_t            ctl,
    input  logic [ADDR_W-1:0]   target,
    input  logic [ADDR_W-1:0]   npc,
    input  logic                squash_q,
    output logic [ADDR_W-1:0]   nnpc,
    output logic                slot_next,
    output logic                squash_next
);

    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(INSTR_BYTES - 1);

    logic live_br;
    logic redirect;
    logic mispredict;

    // Qualify the branch and pick the sequential or target address.
    always_comb begin
        live_br     = ctl.is_br && !squash_q;
        redirect    = live_br && ctl.taken;
        mispredict  = ctl.taken != ctl.pred;
        nnpc        = redirect ? (target & ~ALIGN_MASK) : (npc + STEP);
        slot_next   = live_br;
        squash_next = live_br && ctl.annul && mispredict;
    end

endmodule

// File: rtl/dbs_pc_chain.sv
// Module dbs_pc_chain
// Holds the issue and fetch address registers plus the per-instruction slot
// and squash flags, advancing them in lockstep or reloading on restart.
// Assumes: restart values are prepared by the context store; reset synchronous.
module dbs_pc_chain #(
    parameter int                ADDR_W      = 32,
    parameter int                INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 32'h0000_1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [ADDR_W-1:0]   nnpc,
    input  logic                slot_next,
    input  logic                squash_next,
    input  logic [ADDR_W-1:0]   rs_pc,
    input  logic [ADDR_W-1:0]   rs_npc,
    input  logic                rs_slot,
    output logic [ADDR_W-1:0]   pc,
    output logic [ADDR_W-1:0]   npc,
    output logic                slot_q,
    output logic                squash_q
);

    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(INSTR_BYTES - 1);
    localparam logic [ADDR_W-1:0] VEC_ALIGN  = RESET_VEC & ~ALIGN_MASK;

    // Shift the address chain one step, or reload it from the restart context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= VEC_ALIGN;
            npc      <= VEC_ALIGN + STEP;
            slot_q   <= 1'b0;
            squash_q <= 1'b0;
        end else if (restart) begin
            pc       <= rs_pc;
            npc      <= rs_npc;
            slot_q   <= rs_slot;
            squash_q <= 1'b0;
        end else begin
            pc       <= npc;
            npc      <= nnpc;
            slot_q   <= slot_next;
            squash_q <= squash_next;
        end
    end

    // R2: without restart the fetched address issues next.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> pc == $past(npc));

    // R10: restart reloads the issue address from the context store.
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pc == $past(rs_pc)) && (npc == $past(rs_npc)) && !squash_q);

    // R6: a squashed slot never produces a squash of its own.
    p_single_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        squash_q |=> !squash_q);

endmodule

// File: rtl/dbs_save_ctx.sv
// Module dbs_save_ctx
// Records the restart context of each committed issue and derives the
// addresses a restart reloads.
// Assumes: capture is suppressed for squashed and restart cycles.
module dbs_save_ctx #(
    parameter int                ADDR_W      = 32,
    parameter int                INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 32'h0000_1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_en,
    input  logic [ADDR_W-1:0]   pc,
    input  logic                slot_q,
    input  logic [ADDR_W-1:0]   npc,
    output logic [ADDR_W-1:0]   sv_pc,
    output logic                sv_slot,
    output logic [ADDR_W-1:0]   sv_tgt,
    output logic [ADDR_W-1:0]   rs_pc,
    output logic [ADDR_W-1:0]   rs_npc,
    output logic                rs_slot
);

    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(INSTR_BYTES - 1);
    localparam logic [ADDR_W-1:0] VEC_ALIGN  = RESET_VEC & ~ALIGN_MASK;

    // Latch the context of the instruction committing this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_pc   <= VEC_ALIGN;
            sv_slot <= 1'b0;
            sv_tgt  <= VEC_ALIGN + STEP;
        end else if (capture_en) begin
            sv_pc   <= pc;
            sv_slot <= slot_q;
            sv_tgt  <= npc;
        end
    end

    // Choose the replay addresses from the stored context.
    always_comb begin
        rs_pc   = sv_pc;
        rs_npc  = sv_slot ? sv_tgt : (sv_pc + STEP);
        rs_slot = sv_slot;
    end

    // R6: a cancelled or replayed cycle leaves the context untouched.
    p_ctx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable(sv_pc) && $stable(sv_slot) && $stable(sv_tgt));

    // R9: a committed cycle records the issuing address.
    p_ctx_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (sv_pc == $past(pc)) && (sv_tgt == $past(npc)));

endmodule

// File: rtl/dbs_pc_sequencer.sv
// Module dbs_pc_sequencer
// Fetch address sequencer with one architectural branch delay slot,
// annulling branches and a restart context for traps on slot instructions.
// Assumes: one instruction issues per cycle at issue_pc; decode inputs refer
// to it; INSTR_BYTES is a power of two.
module dbs_pc_sequencer
    import dbs_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                INSTR_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 32'h0000_1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_branch,
    input  logic                dec_taken,
    input  logic                dec_annul,
    input  logic                dec_pred,
    input  logic [ADDR_W-1:0]   dec_target,
    input  logic                trap_restart,
    output logic [ADDR_W-1:0]   issue_pc,
    output logic [ADDR_W-1:0]   fetch_pc,
    output logic [ADDR_W-1:0]   next_next_pc,
    output logic                squash,
    output logic                in_slot,
    output logic [ADDR_W-1:0]   saved_pc,
    output logic                saved_in_slot,
    output logic [ADDR_W-1:0]   saved_target
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(INSTR_BYTES - 1);

    dbs_ctl_t          ctl;
    logic [ADDR_W-1:0] pc_w, npc_w, nnpc_w;
    logic [ADDR_W-1:0] rs_pc_w, rs_npc_w;
    logic              rs_slot_w;
    logic              slot_next_w, squash_next_w;
    logic              slot_w, squash_w;
    logic              capture_en;

    // Bundle the decode inputs and gate context capture.
    always_comb begin
        ctl        = '{is_br: dec_branch, taken: dec_taken,
                       annul: dec_annul, pred: dec_pred};
        capture_en = !squash_w && !trap_restart;
    end

    dbs_next_addr #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_next (
        .ctl         (ctl),
        .target      (dec_target),
        .npc         (npc_w),
        .squash_q    (squash_w),
        .nnpc        (nnpc_w),
        .slot_next   (slot_next_w),
        .squash_next (squash_next_w)
    );

    dbs_pc_chain #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES),
        .RESET_VEC   (RESET_VEC)
    ) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (trap_restart),
        .nnpc        (nnpc_w),
        .slot_next   (slot_next_w),
        .squash_next (squash_next_w),
        .rs_pc       (rs_pc_w),
        .rs_npc      (rs_npc_w),
        .rs_slot     (rs_slot_w),
        .pc          (pc_w),
        .npc         (npc_w),
        .slot_q      (slot_w),
        .squash_q    (squash_w)
    );

    dbs_save_ctx #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES),
        .RESET_VEC   (RESET_VEC)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_en  (capture_en),
        .pc          (pc_w),
        .slot_q      (slot_w),
        .npc         (npc_w),
        .sv_pc       (saved_pc),
        .sv_slot     (saved_in_slot),
        .sv_tgt      (saved_target),
        .rs_pc       (rs_pc_w),
        .rs_npc      (rs_npc_w),
        .rs_slot     (rs_slot_w)
    );

    // Drive the address and status outputs.
    always_comb begin
        issue_pc     = pc_w;
        fetch_pc     = npc_w;
        next_next_pc = nnpc_w;
        squash       = squash_w;
        in_slot      = slot_w;
    end

    // R3: a live taken branch makes its aligned target the next fetch address.
    p_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_branch && dec_taken && !squash && !trap_restart)
        |=> fetch_pc == ($past(dec_target) & ~ALIGN_MASK));

    // R8: the instruction behind a live branch is flagged as a slot.
    p_slot_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_branch && !squash && !trap_restart) |=> in_slot);

    // R5: a mispredicted annulling branch cancels its slot.
    p_annul_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_branch && dec_annul && (dec_taken != dec_pred) && !squash && !trap_restart)
        |=> squash);

    // R11: issue and fetch addresses stay word aligned.
    p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_pc & ALIGN_MASK) == '0) && ((fetch_pc & ALIGN_MASK) == '0));

endmodule

// File: tb/dbs_pc_sequencer_tb.sv
// Bench for dbs_pc_sequencer: directed cases for each requirement, then a
// random run, all compared every cycle against a behavioural model.
module dbs_pc_sequencer_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RV         = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_branch, dec_taken, dec_annul, dec_pred, trap_restart;
    logic [31:0] dec_target;
    logic [31:0] issue_pc, fetch_pc, next_next_pc, saved_pc, saved_target;
    logic        squash, in_slot, saved_in_slot;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;

    // Behavioural model state.
    logic [31:0] m_pc, m_npc, m_spc, m_stgt;
    logic        m_sq, m_slot, m_sslot;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbs_pc_sequencer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_branch    (dec_branch),
        .dec_taken     (dec_taken),
        .dec_annul     (dec_annul),
        .dec_pred      (dec_pred),
        .dec_target    (dec_target),
        .trap_restart  (trap_restart),
        .issue_pc      (issue_pc),
        .fetch_pc      (fetch_pc),
        .next_next_pc  (next_next_pc),
        .squash        (squash),
        .in_slot       (in_slot),
        .saved_pc      (saved_pc),
        .saved_in_slot (saved_in_slot),
        .saved_target  (saved_target)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_nn();
        if (!m_sq && dec_branch && dec_taken) return dec_target & ~32'h3;
        return m_npc + 32'd4;
    endfunction

    task automatic compare_all();
        chk("R2 issue_pc", issue_pc, m_pc);
        chk("R2 fetch_pc", fetch_pc, m_npc);
        chk("R3 next_next_pc", next_next_pc, model_nn());
        chk("R5 squash", {31'b0, squash}, {31'b0, m_sq});
        chk("R8 in_slot", {31'b0, in_slot}, {31'b0, m_slot});
        chk("R9 saved_pc", saved_pc, m_spc);
        chk("R9 saved_in_slot", {31'b0, saved_in_slot}, {31'b0, m_sslot});
        chk("R9 saved_target", saved_target, m_stgt);
    endtask

    task automatic model_step();
        logic [31:0] nn;
        logic live;
        if (trap_restart) begin
            m_pc   = m_spc;
            m_npc  = m_sslot ? m_stgt : m_spc + 32'd4;
            m_slot = m_sslot;
            m_sq   = 1'b0;
        end else begin
            nn   = model_nn();
            live = dec_branch && !m_sq;
            if (!m_sq) begin
                m_spc   = m_pc;
                m_sslot = m_slot;
                m_stgt  = m_npc;
            end
            m_sq   = live && dec_annul && (dec_taken != dec_pred);
            m_slot = live;
            m_pc   = m_npc;
            m_npc  = nn;
        end
    endtask

    // One issue cycle: drive, compare, clock, update model, settle.
    task automatic drive(input logic br, input logic tk, input logic an, input logic pr,
                         input logic [31:0] tgt, input logic rs);
        dec_branch   = br;
        dec_taken    = tk;
        dec_annul    = an;
        dec_pred     = pr;
        dec_target   = tgt;
        trap_restart = rs;
        #1;
        if (model_on) compare_all();
        @(posedge clk);
        if (model_on) model_step();
        @(negedge clk);
        #1;
    endtask

    task automatic nop();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEE0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] a, b, sp;
        rst_n = 1'b0;
        dec_branch = 0; dec_taken = 0; dec_annul = 0; dec_pred = 0;
        dec_target = 32'h0; trap_restart = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset values
        chk("R1 issue_pc", issue_pc, RV);
        chk("R1 fetch_pc", fetch_pc, RV + 32'd4);
        chk("R1 next_next_pc", next_next_pc, RV + 32'd8);
        chk("R1 squash", {31'b0, squash}, 32'd0);
        chk("R1 in_slot", {31'b0, in_slot}, 32'd0);
        m_pc = RV; m_npc = RV + 32'd4; m_sq = 0; m_slot = 0;
        m_spc = RV; m_sslot = 0; m_stgt = RV + 32'd4;
        rst_n = 1'b1;
        model_on = 1'b1;

        // R2: sequential issue
        nop(); nop(); nop();
        chk("R2 sequential issue", issue_pc, RV + 32'h0C);

        // R3 / R8: taken branch, slot, then target
        a = issue_pc;
        drive(1, 1, 0, 0, 32'h0000_2000, 0);
        chk("R3 slot issues", issue_pc, a + 32'd4);
        chk("R8 slot flagged", {31'b0, in_slot}, 32'd1);
        nop();
        chk("R3 target issues", issue_pc, 32'h0000_2000);
        chk("R8 flag clears", {31'b0, in_slot}, 32'd0);

        // R4: not taken
        a = issue_pc;
        drive(1, 0, 0, 0, 32'h0000_3000, 0);
        nop();
        chk("R4 fall through", issue_pc, a + 32'd8);

        // R5 / R6: mispredicted annulling branch, ignored branch in the slot
        a = issue_pc;
        drive(1, 0, 1, 1, 32'h0000_3000, 0);
        chk("R5 squash raised", {31'b0, squash}, 32'd1);
        chk("R5 slot issues", issue_pc, a + 32'd4);
        sp = saved_pc;
        drive(1, 1, 1, 0, 32'h0000_7000, 0);
        chk("R6 issue sequential", issue_pc, a + 32'd8);
        chk("R6 fetch sequential", fetch_pc, a + 32'd12);
        chk("R6 no repeat squash", {31'b0, squash}, 32'd0);
        chk("R6 context held", saved_pc, sp);

        // R5: annulling branch with matching prediction
        drive(1, 1, 1, 1, 32'h0000_2400, 0);
        chk("R5 no squash on match", {31'b0, squash}, 32'd0);
        nop();
        chk("R5 taken to target", issue_pc, 32'h0000_2400);

        // R7: branch in a delay slot
        a = issue_pc;
        drive(1, 1, 0, 0, 32'h0000_4000, 0);
        drive(1, 1, 0, 0, 32'h0000_5000, 0);
        chk("R7 first target", issue_pc, 32'h0000_4000);
        nop();
        chk("R7 second target", issue_pc, 32'h0000_5000);

        // R10: restart onto a slot instruction
        a = issue_pc;
        drive(1, 1, 0, 0, 32'h0000_6000, 0);
        nop();
        drive(1, 1, 0, 0, 32'h0000_9990, 1);
        chk("R10 restart issue", issue_pc, a + 32'd4);
        chk("R10 restart fetch from target", fetch_pc, 32'h0000_6000);
        chk("R10 restart slot flag", {31'b0, in_slot}, 32'd1);
        nop();
        chk("R10 reaches target", issue_pc, 32'h0000_6000);

        // R10: restart onto an ordinary instruction
        nop();
        b = issue_pc;
        nop();
        drive(0, 0, 0, 0, 32'h0, 1);
        chk("R10 plain restart issue", issue_pc, b);
        chk("R10 plain restart fetch", fetch_pc, b + 32'd4);

        // R11: unaligned target
        drive(1, 1, 0, 0, 32'h0000_8003, 0);
        chk("R11 aligned fetch", fetch_pc, 32'h0000_8000);
        nop();

        // Random run against the model
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 3) == 0, $urandom % 2, ($urandom % 2) == 0,
                  $urandom % 2, $urandom, ($urandom % 40) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule